// File: doc/BRIEF.md
# Multiplexed Decade Digit Readout with Leading-Zero Blanking

This block sits between the eight decade stages of a frequency counter and a display readout. The block stores no digits of its own. It receives all eight BCD digits in parallel. A readout controller outside the block steps a column select through the columns. For each select value the block places one digit on a shared 4-bit bus, and with it two flags: a blank flag that tells the character generator to show nothing, and a marker flag that tells it to draw the overflow symbol.

Blanking follows the usual rule for counters. A zero is hidden while every column to its left is also zero. The first nonzero column and every column to its right are shown, and so are zeros inside the number. The rightmost column is always shown, so an empty count reads as a single 0. When the counter has overflowed, the leftmost column carries a marker code in place of its digit. The decision and the mux are combinational. The result is registered once at the bus.

Top module: `readout_mux_blank`

## Requirements
- R1: With select value k in 0..7, digit_o carries digit k of digits_i (bits 4k+3..4k). Digit 0 is the least significant and column 7 is the leftmost.
- R2: The outputs change only on a rising clock edge and reflect the inputs present before that edge, which gives one clock of latency.
- R3: For k in 1..7 (and not the overflow case of R5), blank_o is 1 exactly when digits k through 7 are all zero. A blanked column still carries 0 on digit_o.
- R4: Column 0 is never blanked. An all-zero count shows one 0 there.
- R5: When overflow_i is 1 and the select is 7, digit_o is 4'hA (the marker code), marker_o is 1 and blank_o is 0.
- R6: marker_o is 0 for every select other than 7. Overflow does not change the digit or blank outputs of columns 0..6.
- R7: A select value from 8 to 15 gives digit_o = 4'hF, blank_o = 1 and marker_o = 0.
- R8: While rst_n is low, and on the first cycles after it rises until a clock edge samples the inputs, digit_o is 0, blank_o is 1 and marker_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits_i | input | 32 | Eight BCD digits, digit k in bits 4k+3..4k |
| overflow_i | input | 1 | Counter has overflowed |
| col_sel_i | input | 4 | Column select from the readout controller |
| digit_o | output | 4 | Digit or special code on the shared bus |
| blank_o | output | 1 | Column is to be shown blank |
| marker_o | output | 1 | Column shows the overflow marker |

## Verification
The hardest situation to reach is an overflow on a count that has wrapped to zero, or nearly to zero. In that case the marker takes the leftmost column, and the blanking of the columns below it must still follow the digits alone. The bench drives overflow with an all-zero count and with a count whose leading zeros stop below column 7. It sweeps every column in both cases, so the interaction of marker and blanking is seen column by column. Counts that hold zeros inside the number are used as well, to confirm that blanking stops at the first nonzero digit.

// File: rtl/readout_pkg.sv
package readout_pkg;

    localparam int DIGIT_W = 4;

    typedef struct packed {
        logic [DIGIT_W-1:0] digit;
        logic               blank;
        logic               marker;
    } rdout_t;

endpackage

// File: rtl/readout_zero_scan.sv
// Per-column "shown" decision: column k is shown when it or any column
// to its left holds a nonzero digit; column 0 is always shown.
module readout_zero_scan #(
    parameter int NUM_DIGITS = 8,
    parameter int DIGIT_W    = 4
) (
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    output logic [NUM_DIGITS-1:0]         shown_o
);

    logic [NUM_DIGITS-1:0] nonzero;
    logic [NUM_DIGITS-1:0] seen;

    genvar k;
    generate
        for (k = 0; k < NUM_DIGITS; k++) begin : g_col
            assign nonzero[k] = |digits_i[k*DIGIT_W +: DIGIT_W];
            if (k == NUM_DIGITS - 1) begin : g_top
                assign seen[k] = nonzero[k];
            end else begin : g_low
                assign seen[k] = nonzero[k] | seen[k+1];
            end
            if (k == 0) begin : g_lsd
                assign shown_o[k] = 1'b1;
            end else begin : g_upper
                assign shown_o[k] = seen[k];
            end
        end
    endgenerate

endmodule

// File: rtl/readout_digit_sel.sv
// Select one digit and its shown bit by column index; flag range.
module readout_digit_sel #(
    parameter int NUM_DIGITS = 8,
    parameter int DIGIT_W    = 4,
    parameter int SEL_W      = 4
) (
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    input  logic [NUM_DIGITS-1:0]         shown_i,
    input  logic [SEL_W-1:0]              sel_i,
    output logic [DIGIT_W-1:0]            digit_o,
    output logic                          shown_o,
    output logic                          in_range_o
);

    always_comb begin
        digit_o    = '0;
        shown_o    = 1'b0;
        in_range_o = 1'b0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (sel_i == SEL_W'(k)) begin
                digit_o    = digits_i[k*DIGIT_W +: DIGIT_W];
                shown_o    = shown_i[k];
                in_range_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/readout_mux_blank.sv
module readout_mux_blank #(
    parameter int          NUM_DIGITS  = 8,
    parameter int          SEL_W       = 4,
    parameter logic [3:0]  MARKER_CODE = 4'hA,
    parameter logic [3:0]  IDLE_CODE   = 4'hF
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_DIGITS*readout_pkg::DIGIT_W-1:0]   digits_i,
    input  logic                                         overflow_i,
    input  logic [SEL_W-1:0]                             col_sel_i,
    output logic [readout_pkg::DIGIT_W-1:0]              digit_o,
    output logic                                         blank_o,
    output logic                                         marker_o
);
    import readout_pkg::*;

    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NUM_DIGITS - 1);

    logic [NUM_DIGITS-1:0] shown;
    logic [DIGIT_W-1:0]    sel_digit;
    logic                  sel_shown;
    logic                  sel_in_range;

    rdout_t out_d, out_q;

    readout_zero_scan #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_W    (DIGIT_W)
    ) u_scan (
        .digits_i (digits_i),
        .shown_o  (shown)
    );

    readout_digit_sel #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIGIT_W    (DIGIT_W),
        .SEL_W      (SEL_W)
    ) u_sel (
        .digits_i   (digits_i),
        .shown_i    (shown),
        .sel_i      (col_sel_i),
        .digit_o    (sel_digit),
        .shown_o    (sel_shown),
        .in_range_o (sel_in_range)
    );

    always_comb begin
        out_d = '{digit: sel_digit, blank: ~sel_shown, marker: 1'b0};
        if (!sel_in_range) begin
            out_d = '{digit: IDLE_CODE, blank: 1'b1, marker: 1'b0};
        end else if (overflow_i && (col_sel_i == TOP_SEL)) begin
            out_d = '{digit: MARKER_CODE, blank: 1'b0, marker: 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{digit: '0, blank: 1'b1, marker: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign digit_o  = out_q.digit;
    assign blank_o  = out_q.blank;
    assign marker_o = out_q.marker;

    // R4: least significant column is never blank
    a_r4_lsd_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_i == '0) |=> !blank_o);

    // R5: overflow on the top column yields the marker
    a_r5_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_i && col_sel_i == TOP_SEL) |=>
            (marker_o && !blank_o && digit_o == MARKER_CODE));

    // R6: no marker on any other column
    a_r6_marker_only_top: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_i != TOP_SEL) |=> !marker_o);

    // R7: out-of-range select drives idle code, blanked
    a_r7_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_i > TOP_SEL) |=> (blank_o && !marker_o && digit_o == IDLE_CODE));

    // R3: an in-range blanked column carries zero
    a_r3_blank_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_i <= TOP_SEL) |=> (!blank_o || digit_o == '0));

    // R1: an in-range, non-marker column repeats the selected digit
    a_r1_digit_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_i <= TOP_SEL && !(overflow_i && col_sel_i == TOP_SEL)) |=>
            (digit_o == $past(sel_digit)));

endmodule

// File: tb/tb_readout_mux_blank.sv
module tb_readout_mux_blank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] digits = '0;
    logic        ovf = 1'b0;
    logic [3:0]  sel = '0;
    logic [3:0]  digit_o;
    logic        blank_o;
    logic        marker_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;  // 250 MHz

    readout_mux_blank dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .digits_i   (digits),
        .overflow_i (ovf),
        .col_sel_i  (sel),
        .digit_o    (digit_o),
        .blank_o    (blank_o),
        .marker_o   (marker_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, logic [3:0] ed, logic eb, logic em);
        checks++;
        if (digit_o !== ed || blank_o !== eb || marker_o !== em) begin
            errors++;
            $display("FAIL %s sel=%0d actual d=%h b=%b m=%b expected d=%h b=%b m=%b",
                     req, sel, digit_o, blank_o, marker_o, ed, eb, em);
        end
    endtask

    // Expected outputs from the requirements
    task automatic expect_col(input logic [31:0] d, input logic o, input int s,
                              output logic [3:0] ed, output logic eb,
                              output logic em, output string req);
        logic upper_zero;
        if (s > 7) begin
            ed = 4'hF; eb = 1'b1; em = 1'b0; req = "R7";
        end else if (o && s == 7) begin
            ed = 4'hA; eb = 1'b0; em = 1'b1; req = "R5";
        end else begin
            upper_zero = 1'b1;
            for (int j = s; j < 8; j++) if (d[4*j +: 4] != 4'h0) upper_zero = 1'b0;
            ed = d[4*s +: 4];
            eb = (s != 0) && upper_zero;
            em = 1'b0;
            if (o) req = "R6";
            else if (s == 0) req = "R4";
            else if (eb) req = "R3";
            else req = "R1";
        end
    endtask

    task automatic apply_and_check(input int s);
        logic [3:0] ed; logic eb; logic em; string req;
        @(negedge clk);
        sel = 4'(s);
        @(posedge clk);
        @(negedge clk);
        expect_col(digits, ovf, s, ed, eb, em, req);
        check(req, ed, eb, em);
    endtask

    task automatic sweep(input logic [31:0] d, input logic o);
        @(negedge clk);
        digits = d;
        ovf = o;
        for (int s = 0; s < 16; s++) apply_and_check(s);
    endtask

    task automatic test_reset;
        @(negedge clk);
        check("R8", 4'h0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8", 4'h0, 1'b1, 1'b0);
    endtask

    // R2: change select between edges; output holds until the next edge
    task automatic test_latency;
        @(negedge clk);
        digits = 32'h87654321;
        ovf = 1'b0;
        sel = 4'd2;
        @(posedge clk);
        @(negedge clk);
        check("R2", 4'h3, 1'b0, 1'b0);
        sel = 4'd5;
        #1;
        check("R2", 4'h3, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        check("R2", 4'h6, 1'b0, 1'b0);
    endtask

    task automatic test_all_zero;       sweep(32'h00000000, 1'b0); endtask
    task automatic test_inner_zeros;    sweep(32'h00012030, 1'b0); endtask
    task automatic test_full_width;     sweep(32'h90000000, 1'b0); endtask
    task automatic test_single_lsd;     sweep(32'h00000007, 1'b0); endtask
    task automatic test_ovf_wrapped;    sweep(32'h00000000, 1'b1); endtask
    task automatic test_ovf_partial;    sweep(32'h00400500, 1'b1); endtask
    task automatic test_ovf_top_digit;  sweep(32'h50000001, 1'b1); endtask

    initial begin
        test_reset();
        test_latency();
        test_all_zero();
        test_inner_zeros();
        test_full_width();
        test_single_lsd();
        test_ovf_wrapped();
        test_ovf_partial();
        test_ovf_top_digit();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule